// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block drives one complete page-program operation onto an 8-bit NAND command/address/data port, one bus cycle per clock. After a start pulse it latches the page number, page size, address cycle count and spare layout. It sends the program setup command, the column and row address bytes, and the page data in 512-byte chunks. Around each chunk it pulses the strobes that restart and capture an external ECC engine. It then writes the spare area and the program confirm command. Next it waits for the device's ready line, stopping at a cycle limit, and finally reads the status byte and reports the outcome.

Page data and spare bytes are supplied by the surrounding logic on two byte inputs. A one-cycle take strobe marks the cycle in which the current byte is consumed, and the next byte must be present from the following cycle. The spare area can go in one piece after all data chunks. In the interleaved layout it goes as one 16-byte segment after each chunk. Pin timing of the flash device and the ECC arithmetic sit outside the block.

Top module: `nand_prog_seq`

## Requirements
- R1: A run opens with one write cycle of 0x80 flagged as command (bus_cle=1), followed by column address cycles (bus_ale=1) of value 0x00. There is one column cycle when page_size is 2'b00 (512 bytes) and two when page_size is 2'b01 (2048) or 2'b1x (4096).
- R2: Row address bytes follow the column bytes, least significant byte first: page_addr[7:0], then page_addr[15:8]. Let extra = addr_cycles minus 1 for 512-byte pages, or addr_cycles otherwise. page_addr[23:16] is also sent when extra is nonzero, and page_addr[31:24] is sent as well when extra equals 2.
- R3: Exactly one ecc_clear pulse lies between the last address cycle and the first data byte. Each 512-byte data chunk is preceded by one ecc_start pulse and followed by one ecc_capture pulse. These strobes never coincide with a bus cycle.
- R4: Each data chunk is 512 write cycles with bus_cle=bus_ale=0. Each cycle carries the current wr_data byte and is marked by data_take. A page has 1, 4 or 8 chunks for page_size 2'b00, 2'b01 and 2'b1x.
- R5: With infix_mode=0, the last ecc_capture is followed by 16 spare write cycles per chunk, taken from spare_data and marked by spare_take. A command cycle of 0x10 follows them.
- R6: With infix_mode=1, each ecc_capture is followed at once by 16 spare write cycles, and no spare bytes come after the last chunk's segment. The 0x10 command follows the last segment.
- R7: After the 0x10 command, the block samples nand_rdy once per cycle. If ready stays low for POLL_LIMIT (default 100) cycles, done comes 1+POLL_LIMIT cycles after the 0x10 cycle with err_code=2'b01, and no status cycles are issued.
- R8: Once ready is seen, the block sends command 0x70 and then one read cycle (bus_re=1) that samples status_in. err_code becomes 2'b10 if status_in bit 0 is set and 2'b00 otherwise.
- R9: done is a one-cycle pulse while busy is high, and busy falls in the next cycle. err_code reads 2'b00 throughout a run and keeps the final result after done until the next accepted start.
- R10: A start pulse while busy is high is ignored. The running sequence, including its latched page number, continues unchanged.
- R11: After reset, busy, done, every bus and ECC strobe, and err_code are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, taken only while idle |
| page_addr | input | 32 | Page (row) number |
| page_size | input | 2 | 00: 512 B, 01: 2048 B, 1x: 4096 B |
| addr_cycles | input | 3 | Total address cycles of the device |
| infix_mode | input | 1 | 1: spare segment after each chunk |
| wr_data | input | 8 | Current page data byte |
| spare_data | input | 8 | Current spare byte |
| nand_rdy | input | 1 | Device ready level |
| status_in | input | 8 | Status byte returned on a read cycle |
| bus_we | output | 1 | Write cycle on the byte port |
| bus_re | output | 1 | Read cycle on the byte port |
| bus_cle | output | 1 | Cycle is a command |
| bus_ale | output | 1 | Cycle is an address |
| bus_dout | output | 8 | Byte written in this cycle |
| data_take | output | 1 | wr_data consumed this cycle |
| spare_take | output | 1 | spare_data consumed this cycle |
| ecc_clear | output | 1 | Clear stale ECC state |
| ecc_start | output | 1 | Restart ECC for a chunk |
| ecc_capture | output | 1 | Capture ECC of a finished chunk |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 2 | 00 ok, 01 timeout, 10 program fail |

## Verification
Each state owns a single bus cycle type, so a wrong state or a miscounted byte index appears in the very cycle it happens. It shows up as a byte of the wrong kind or value on the port, or as an ECC strobe in the wrong place. An ordered comparison of every bus and ECC strobe against an independently built expected stream catches it at once. A wrong chunk or spare count changes the total length of the stream, so it is caught at the latest when the confirm command arrives early or late. A wrong timer or status decode is visible only at done, through err_code and the cycle distance from the confirm command.

// File: rtl/nps_pkg.sv
// Shared types and command bytes for the NAND page program sequencer.
// Assumes a single 8-bit byte port with one bus cycle per clock.
package nps_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_SETUP,
        S_COL,
        S_ROW,
        S_ECLR,
        S_ESTART,
        S_DATA,
        S_ECAP,
        S_ISPARE,
        S_SPARE,
        S_CONFIRM,
        S_WAIT,
        S_STCMD,
        S_STRD,
        S_FIN
    } seq_state_e;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_TIMEOUT = 2'b01,
        ERR_PROG    = 2'b10
    } seq_err_e;

    localparam logic [7:0] CMD_SETUP   = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'h10;
    localparam logic [7:0] CMD_STATUS  = 8'h70;
    localparam int         FAIL_BIT    = 0;

    localparam int PAGE_SMALL = 512;
    localparam int PAGE_MID   = 2048;
    localparam int PAGE_LARGE = 4096;

endpackage

// File: rtl/nps_counter.sv
// Generic up-counter with synchronous clear.
// Assumes the caller never lets it wrap within one count window.
module nps_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    // Count up, clear on request or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (inc)      q <= q + W'(1);
    end

endmodule

// File: rtl/nps_poll_timer.sv
// Ready-poll timer: counts cycles while run is high and flags the
// last permitted cycle. Assumes run drops between wait windows.
module nps_poll_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt;

    // Count cycles spent waiting; restart whenever waiting stops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + TW'(1);
    end

    // Flag the final cycle of the wait window.
    always_comb expired = run && (cnt == TW'(LIMIT - 1));

endmodule

// File: rtl/nps_addr_plan.sv
// Address and layout planner: from the latched page size and address
// cycle count it derives the column and row cycle counts, the chunk
// count, the trailing spare length and the row byte for a given slot.
// Assumes addr_cycles describes a real device (no check is made).
module nps_addr_plan
    import nps_pkg::*;
#(
    parameter int CHUNK_BYTES     = 512,
    parameter int SPARE_PER_CHUNK = 16,
    parameter int ACYC_W          = 3,
    parameter int CNT_W           = 10,
    parameter int CHK_W           = 4
) (
    input  logic [1:0]        size_sel,
    input  logic [ACYC_W-1:0] acyc,
    input  logic [31:0]       page,
    input  logic [1:0]        row_sel,
    output logic [CNT_W-1:0]  col_n,
    output logic [CNT_W-1:0]  row_n,
    output logic [CHK_W-1:0]  chunk_n,
    output logic [CNT_W-1:0]  spare_n,
    output logic [7:0]        row_byte
);

    localparam int CH_SMALL = PAGE_SMALL / CHUNK_BYTES;
    localparam int CH_MID   = PAGE_MID   / CHUNK_BYTES;
    localparam int CH_LARGE = PAGE_LARGE / CHUNK_BYTES;

    logic              small_pg;
    logic [ACYC_W-1:0] extra;

    // Cycle counts derived from page size and total address cycles.
    always_comb begin
        small_pg = (size_sel == 2'b00);
        extra    = acyc - ACYC_W'(small_pg);
        col_n    = small_pg ? CNT_W'(1) : CNT_W'(2);
        row_n    = CNT_W'(2) + CNT_W'(extra != '0) + CNT_W'(extra == ACYC_W'(2));
        case (size_sel)
            2'b00:   chunk_n = CHK_W'(CH_SMALL);
            2'b01:   chunk_n = CHK_W'(CH_MID);
            default: chunk_n = CHK_W'(CH_LARGE);
        endcase
        spare_n  = CNT_W'(int'(chunk_n) * SPARE_PER_CHUNK);
    end

    // Row byte selection, least significant byte first.
    always_comb begin
        case (row_sel)
            2'd0:    row_byte = page[7:0];
            2'd1:    row_byte = page[15:8];
            2'd2:    row_byte = page[23:16];
            default: row_byte = page[31:24];
        endcase
    end

endmodule

// File: rtl/nand_prog_seq.sv
// NAND page program sequencer top. One state per bus cycle type; a
// shared byte index counts cycles inside a state and clears on every
// state change. A chunk counter tracks 512-byte chunks. Assumes the
// byte sources hold the current byte until its take strobe.
module nand_prog_seq
    import nps_pkg::*;
#(
    parameter int CHUNK_BYTES     = 512,
    parameter int SPARE_PER_CHUNK = 16,
    parameter int POLL_LIMIT      = 100,
    parameter int ACYC_W          = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       page_addr,
    input  logic [1:0]        page_size,
    input  logic [ACYC_W-1:0] addr_cycles,
    input  logic              infix_mode,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        spare_data,
    input  logic              nand_rdy,
    input  logic [7:0]        status_in,
    output logic              bus_we,
    output logic              bus_re,
    output logic              bus_cle,
    output logic              bus_ale,
    output logic [7:0]        bus_dout,
    output logic              data_take,
    output logic              spare_take,
    output logic              ecc_clear,
    output logic              ecc_start,
    output logic              ecc_capture,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code
);

    localparam int MAX_SPARE = (PAGE_LARGE / CHUNK_BYTES) * SPARE_PER_CHUNK;
    localparam int CNT_W     = $clog2(CHUNK_BYTES + MAX_SPARE + 1);
    localparam int CHK_W     = $clog2(PAGE_LARGE / CHUNK_BYTES + 1);

    seq_state_e        state, state_n;
    seq_err_e          err_q, err_n;
    logic [31:0]       page_q;
    logic [1:0]        size_q;
    logic [ACYC_W-1:0] acyc_q;
    logic              infix_q;

    logic [CNT_W-1:0]  idx;
    logic [CHK_W-1:0]  chunk;
    logic              idx_clr, chunk_clr, chunk_inc;
    logic              poll_run, poll_expired;

    logic [CNT_W-1:0]  col_n, row_n, spare_n;
    logic [CHK_W-1:0]  chunk_n;
    logic [7:0]        row_byte;
    logic              last_chunk;
    logic              status_unused;

    nps_addr_plan #(
        .CHUNK_BYTES     (CHUNK_BYTES),
        .SPARE_PER_CHUNK (SPARE_PER_CHUNK),
        .ACYC_W          (ACYC_W),
        .CNT_W           (CNT_W),
        .CHK_W           (CHK_W)
    ) u_plan (
        .size_sel (size_q),
        .acyc     (acyc_q),
        .page     (page_q),
        .row_sel  (idx[1:0]),
        .col_n    (col_n),
        .row_n    (row_n),
        .chunk_n  (chunk_n),
        .spare_n  (spare_n),
        .row_byte (row_byte)
    );

    nps_counter #(.W(CNT_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (idx_clr),
        .inc   (1'b1),
        .q     (idx)
    );

    nps_counter #(.W(CHK_W)) u_chunk (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (chunk_clr),
        .inc   (chunk_inc),
        .q     (chunk)
    );

    nps_poll_timer #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (poll_run),
        .expired (poll_expired)
    );

    // Only the fail bit of the status byte matters.
    assign status_unused = ^{status_in[7:1]};

    // Next-state and result selection.
    always_comb begin
        state_n    = state;
        err_n      = err_q;
        last_chunk = (chunk == chunk_n - CHK_W'(1));
        case (state)
            S_IDLE:    if (start) begin
                           state_n = S_SETUP;
                           err_n   = ERR_NONE;
                       end
            S_SETUP:   state_n = S_COL;
            S_COL:     if (idx == col_n - CNT_W'(1)) state_n = S_ROW;
            S_ROW:     if (idx == row_n - CNT_W'(1)) state_n = S_ECLR;
            S_ECLR:    state_n = S_ESTART;
            S_ESTART:  state_n = S_DATA;
            S_DATA:    if (idx == CNT_W'(CHUNK_BYTES - 1)) state_n = S_ECAP;
            S_ECAP:    if (infix_q)         state_n = S_ISPARE;
                       else if (last_chunk) state_n = S_SPARE;
                       else                 state_n = S_ESTART;
            S_ISPARE:  if (idx == CNT_W'(SPARE_PER_CHUNK - 1))
                           state_n = last_chunk ? S_CONFIRM : S_ESTART;
            S_SPARE:   if (idx == spare_n - CNT_W'(1)) state_n = S_CONFIRM;
            S_CONFIRM: state_n = S_WAIT;
            S_WAIT:    if (nand_rdy) state_n = S_STCMD;
                       else if (poll_expired) begin
                           state_n = S_FIN;
                           err_n   = ERR_TIMEOUT;
                       end
            S_STCMD:   state_n = S_STRD;
            S_STRD:    begin
                           state_n = S_FIN;
                           err_n   = status_in[FAIL_BIT] ? ERR_PROG : ERR_NONE;
                       end
            S_FIN:     state_n = S_IDLE;
            default:   state_n = S_IDLE;
        endcase
    end

    // Counter control: index restarts each state, chunks count per restart.
    always_comb begin
        idx_clr   = (state_n != state);
        chunk_clr = (state == S_ECLR);
        chunk_inc = (state_n == S_ESTART) &&
                    ((state == S_ECAP) || (state == S_ISPARE));
        poll_run  = (state == S_WAIT);
    end

    // State and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            err_q <= ERR_NONE;
        end else begin
            state <= state_n;
            err_q <= err_n;
        end
    end

    // Latch the run parameters when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            size_q  <= '0;
            acyc_q  <= '0;
            infix_q <= 1'b0;
        end else if (state == S_IDLE && start) begin
            page_q  <= page_addr;
            size_q  <= page_size;
            acyc_q  <= addr_cycles;
            infix_q <= infix_mode;
        end
    end

    // Bus cycle decode: one cycle type per state.
    always_comb begin
        bus_we      = 1'b0;
        bus_re      = 1'b0;
        bus_cle     = 1'b0;
        bus_ale     = 1'b0;
        bus_dout    = 8'h00;
        data_take   = 1'b0;
        spare_take  = 1'b0;
        case (state)
            S_SETUP:   begin bus_we = 1'b1; bus_cle = 1'b1; bus_dout = CMD_SETUP; end
            S_COL:     begin bus_we = 1'b1; bus_ale = 1'b1; end
            S_ROW:     begin bus_we = 1'b1; bus_ale = 1'b1; bus_dout = row_byte; end
            S_DATA:    begin bus_we = 1'b1; data_take = 1'b1; bus_dout = wr_data; end
            S_ISPARE,
            S_SPARE:   begin bus_we = 1'b1; spare_take = 1'b1; bus_dout = spare_data; end
            S_CONFIRM: begin bus_we = 1'b1; bus_cle = 1'b1; bus_dout = CMD_CONFIRM; end
            S_STCMD:   begin bus_we = 1'b1; bus_cle = 1'b1; bus_dout = CMD_STATUS; end
            S_STRD:    bus_re = 1'b1;
            default:   ;
        endcase
    end

    // ECC strobes and run status.
    always_comb begin
        ecc_clear   = (state == S_ECLR);
        ecc_start   = (state == S_ESTART);
        ecc_capture = (state == S_ECAP);
        busy        = (state != S_IDLE);
        done        = (state == S_FIN);
        err_code    = err_q;
    end

endmodule

// File: rtl/nps_seq_chk.sv
// Port-level protocol checker for nand_prog_seq, attached by bind.
module nps_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_we,
    input logic       bus_re,
    input logic       bus_cle,
    input logic       bus_ale,
    input logic       data_take,
    input logic       spare_take,
    input logic       ecc_clear,
    input logic       ecc_start,
    input logic       ecc_capture,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code
);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ecc_clear, ecc_start, ecc_capture, bus_we, bus_re}));

    // R1
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cle || bus_ale) |-> (bus_we && !(bus_cle && bus_ale)));

    // R4
    take_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_take || spare_take) |-> (bus_we && !bus_cle && !bus_ale));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy ##1 (!done && !busy));

    // R9
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |-> (err_code == 2'b00));

    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(err_code));

    // R8
    err_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'b11);

endmodule

bind nand_prog_seq nps_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_cle     (bus_cle),
    .bus_ale     (bus_ale),
    .data_take   (data_take),
    .spare_take  (spare_take),
    .ecc_clear   (ecc_clear),
    .ecc_start   (ecc_start),
    .ecc_capture (ecc_capture),
    .busy        (busy),
    .done        (done),
    .err_code    (err_code)
);

// File: tb/nand_prog_seq_bench.sv
// Scoreboard bench: run_page pushes the expected bus/ECC stream, the
// monitor pops and compares every observed cycle.
module nand_prog_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] page_addr = '0;
    logic [1:0]  page_size = '0;
    logic [2:0]  addr_cycles = '0;
    logic        infix_mode = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  spare_data = '0;
    logic        nand_rdy = 1'b0;
    logic [7:0]  status_in = '0;
    logic        bus_we, bus_re, bus_cle, bus_ale;
    logic [7:0]  bus_dout;
    logic        data_take, spare_take;
    logic        ecc_clear, ecc_start, ecc_capture;
    logic        busy, done;
    logic [1:0]  err_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int confirm_cyc = 0;
    int dk = 0;
    int sk = 0;

    // item = {kind[2:0], byte}: 0 cmd, 1 addr, 2 write, 3 read, 4 clr, 5 start, 6 capture
    logic [10:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nand_prog_seq u_nand_prog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
        .page_size(page_size), .addr_cycles(addr_cycles), .infix_mode(infix_mode),
        .wr_data(wr_data), .spare_data(spare_data), .nand_rdy(nand_rdy),
        .status_in(status_in), .bus_we(bus_we), .bus_re(bus_re), .bus_cle(bus_cle),
        .bus_ale(bus_ale), .bus_dout(bus_dout), .data_take(data_take),
        .spare_take(spare_take), .ecc_clear(ecc_clear), .ecc_start(ecc_start),
        .ecc_capture(ecc_capture), .busy(busy), .done(done), .err_code(err_code)
    );

    function automatic logic [7:0] dpat(input int k);
        return 8'(k * 7 + 3);
    endfunction

    function automatic logic [7:0] spat(input int k);
        return 8'(k * 13 + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] kind, input logic [7:0] b, input string tag);
        exp_q.push_back({kind, b});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each observed bus or ECC cycle with the queue head.
    logic [10:0] obs, expv;
    logic        have;
    string       etag;
    always @(negedge clk) begin
        if (rst_n) begin
            have = 1'b1;
            if (ecc_clear)        obs = {3'd4, 8'h00};
            else if (ecc_start)   obs = {3'd5, 8'h00};
            else if (ecc_capture) obs = {3'd6, 8'h00};
            else if (bus_re)      obs = {3'd3, 8'h00};
            else if (bus_we)      obs = {bus_cle ? 3'd0 : (bus_ale ? 3'd1 : 3'd2), bus_dout};
            else                  have = 1'b0;
            if (have) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R1 unexpected cycle: actual %h expected none", obs);
                end else begin
                    expv = exp_q.pop_front();
                    etag = tag_q.pop_front();
                    chk(etag, 32'(obs), 32'(expv), "bus stream item");
                end
            end
            if (bus_we && bus_cle && bus_dout == 8'h10) confirm_cyc = cyc;
            if (data_take) begin dk++; wr_data = dpat(dk); end
            if (spare_take) begin sk++; spare_data = spat(sk); end
        end
    end

    // Driver: build the expected stream for one page and run it.
    task automatic run_page(input logic [31:0] pg, input logic [1:0] sel, input logic [2:0] ac,
                            input logic inf, input logic rdy, input logic [7:0] st,
                            input logic poke);
        int extra, nrows, nch, k, s, n;
        logic [1:0] exp_err;
        extra = int'(ac) - ((sel == 2'b00) ? 1 : 0);
        nrows = 2 + ((extra != 0) ? 1 : 0) + ((extra == 2) ? 1 : 0);
        nch   = (sel == 2'b00) ? 1 : ((sel == 2'b01) ? 4 : 8);
        push(3'd0, 8'h80, "R1");
        for (int i = 0; i < ((sel == 2'b00) ? 1 : 2); i++) push(3'd1, 8'h00, "R1");
        for (int i = 0; i < nrows; i++) push(3'd1, 8'(pg >> (8 * i)), "R2");
        push(3'd4, 8'h00, "R3");
        k = 0;
        s = 0;
        for (int c = 0; c < nch; c++) begin
            push(3'd5, 8'h00, "R3");
            for (int b = 0; b < 512; b++) begin push(3'd2, dpat(k), "R4"); k++; end
            push(3'd6, 8'h00, "R3");
            if (inf) for (int b = 0; b < 16; b++) begin push(3'd2, spat(s), "R6"); s++; end
        end
        if (!inf) for (int b = 0; b < 16 * nch; b++) begin push(3'd2, spat(s), "R5"); s++; end
        push(3'd0, 8'h10, inf ? "R6" : "R5");
        if (rdy) begin
            push(3'd0, 8'h70, "R8");
            push(3'd3, 8'h00, "R8");
            exp_err = st[0] ? 2'b10 : 2'b00;
        end else begin
            exp_err = 2'b01;
        end
        @(negedge clk);
        dk = 0; sk = 0;
        wr_data = dpat(0); spare_data = spat(0);
        page_addr = pg; page_size = sel; addr_cycles = ac; infix_mode = inf;
        nand_rdy = rdy; status_in = st;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", 32'(busy), 32'd1, "busy after start");
        n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (poke && n == 20) begin start = 1'b1; page_addr = ~pg; end
            if (n == 21) start = 1'b0;
            if (n > 20000) break;
        end
        chk(rdy ? "R8" : "R7", 32'(err_code), 32'(exp_err), "error code at done");
        chk("R9", 32'(busy), 32'd1, "busy during done");
        if (!rdy) chk("R7", 32'(cyc - confirm_cyc), 32'd101, "timeout distance");
        chk(inf ? "R6" : "R5", 32'(exp_q.size()), 32'd0, "items left after done");
        @(negedge clk);
        chk("R9", 32'({done, busy}), 32'd0, "done and busy after pulse");
        repeat (3) @(negedge clk);
        chk("R9", 32'(err_code), 32'(exp_err), "error code held");
        if (poke) chk("R10", 32'(busy), 32'd0, "no second run after ignored start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", 32'({busy, done, bus_we, bus_re, ecc_clear, ecc_start, ecc_capture}),
            32'd0, "strobes after reset");
        chk("R11", 32'(err_code), 32'd0, "error code after reset");
        // R1 R2: small page, extra = 2 sends four row bytes
        run_page(32'hA1B2C3D4, 2'b00, 3'd3, 1'b0, 1'b1, 8'h00, 1'b0);
        // R8 R10: mid page, status fail bit set, start poked while busy
        run_page(32'h00345678, 2'b01, 3'd5, 1'b0, 1'b1, 8'h01, 1'b1);
        // R6: large page interleaved spare, status without fail bit
        run_page(32'h0F1E2D3C, 2'b10, 3'd4, 1'b1, 1'b1, 8'hE0, 1'b0);
        // R7: device never ready
        run_page(32'h00009876, 2'b00, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0);
        // R6 R2: mid page interleaved, extra = 2
        run_page(32'h44332211, 2'b01, 3'd2, 1'b1, 1'b1, 8'h00, 1'b0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule